// File: doc/BRIEF.md
# Smart card T=0 character receiver

This block receives characters from a card over one shared, open-drain I/O line that uses the T=0 character protocol. While the line idles high, a falling edge starts a character. The receiver then takes ten samples, one in the middle of each elementary time unit: the start bit, eight data bits sent least significant bit first, and one parity bit. Parity is even over the nine bits.

When parity is correct, the byte goes into the receive data register and the receive-full flag is set. When parity is wrong, the parity-error flag is set and the data register and receive-full flag are left alone. The block then pulls the shared line low for one bit time during the error slot, and the card resends the character. Software clears both flags with single-cycle pulses. Receive and error interrupt requests are derived from the flags, an enable and a mask.

The line is split into two signals. `line_in` is the resolved level of the wire. `line_pull_low` asks the pad to sink the wire; when it is 0 the pad is high impedance. The clocks-per-bit count is a parameter, `CPB`, with a default of 372.

Top module: `sc_t0_rx`

## Requirements
- R1: After reset, `rx_data` is 0x00, and `rx_full`, `par_err`, `line_pull_low`, `rxi_req` and `eri_req` are all 0.
- R2: Time t0 is the rising clock edge at which `line_in` is sampled 0 after having been sampled 1 while idle. If `line_in` is 1 at the edge t0+HALF (HALF = floor(CPB/2)), the receiver returns to idle and changes no flag, register or output.
- R3: Bit k of the character is sampled at edge t0+k*CPB+HALF, where k=0 is the start bit, k=1..8 are data bits D0..D7 (least significant bit first) and k=9 is parity.
- R4: When the XOR of the eight data bits and the parity bit is 0, `rx_data` takes the byte and `rx_full` becomes 1 at the edge of the parity sample; `par_err` is unchanged. `rx_data` changes at no other time.
- R5: When that XOR is 1, `par_err` becomes 1 at the edge of the parity sample, and `rx_full` and `rx_data` keep their values.
- R6: After a parity failure, `line_pull_low` is 1 from edge t0+10*CPB+HALF to edge t0+11*CPB+HALF, which is exactly CPB cycles. It is never 1 for a character with good parity.
- R7: `perr_clr` clears `par_err` at the next edge. When a parity failure sets `par_err` at the same edge, the set wins.
- R8: `full_clr` clears `rx_full` at the next edge. When a good character sets `rx_full` at the same edge, the set wins.
- R9: `eri_req` is 1 exactly when `par_err` and `rx_ie` are both 1.
- R10: `rxi_req` is 1 exactly when `rx_full` and `rx_ie` are 1 and `rx_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit lasts CPB cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Resolved level of the shared I/O line |
| line_pull_low | output | 1 | 1 sinks the line low; 0 leaves it high impedance |
| full_clr | input | 1 | Pulse that clears the receive-full flag |
| perr_clr | input | 1 | Pulse that clears the parity-error flag |
| rx_ie | input | 1 | Receive and error interrupt enable |
| rx_mask | input | 1 | Masks the receive request when 1 |
| rx_data | output | 8 | Last character received with good parity |
| rx_full | output | 1 | Receive-full flag |
| par_err | output | 1 | Parity-error flag |
| rxi_req | output | 1 | Receive interrupt request |
| eri_req | output | 1 | Error interrupt request |

## Verification
A behavioural model in the bench follows the wire on every clock and checks all outputs. It exercises good and bad parity, all-zero and all-one bytes, a start glitch shorter than half a bit, and clears that are held high across the very edge at which a flag is set. Each of these catches a different fault:
- A design that let the clear win would never show the flag at all.
- A design that set `rx_full` or overwrote `rx_data` on a bad character would post corrupt data.
- An error pulse that is misplaced or the wrong length would show up as a cycle mismatch on `line_pull_low`.
- A receiver that accepted the glitch would lose alignment with the next character.

// File: rtl/sc_t0_rx.sv
module sc_t0_rx #(
  parameter int CPB = 372
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output logic       line_pull_low,
  input  logic       full_clr,
  input  logic       perr_clr,
  input  logic       rx_ie,
  input  logic       rx_mask,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       par_err,
  output logic       rxi_req,
  output logic       eri_req
);
  localparam int HALF = CPB / 2;
  localparam int PW   = $clog2(CPB);

  logic          line_q, busy;
  logic [PW-1:0] pos;
  logic [3:0]    bitn;
  logic [7:0]    shreg;
  logic          mid, par_bad, full_set, perr_set;

  assign mid      = busy && (pos == PW'(HALF - 1));
  assign par_bad  = ^shreg ^ line_in;
  assign full_set = mid && (bitn == 4'd9) && !par_bad;
  assign perr_set = mid && (bitn == 4'd9) && par_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q        <= 1'b1;
      busy          <= 1'b0;
      pos           <= '0;
      bitn          <= '0;
      shreg         <= '0;
      line_pull_low <= 1'b0;
    end else begin
      line_q <= line_in;
      if (!busy) begin
        if (line_q && !line_in) begin
          busy <= 1'b1;
          pos  <= '0;
          bitn <= '0;
        end
      end else begin
        if (pos == PW'(CPB - 1)) begin
          pos  <= '0;
          bitn <= bitn + 4'd1;
        end else begin
          pos <= pos + 1'b1;
        end
        if (mid) begin
          case (bitn)
            4'd0:    if (line_in) busy <= 1'b0;
            4'd9:    if (!par_bad) busy <= 1'b0;
            4'd10:   line_pull_low <= 1'b1;
            4'd11:   begin line_pull_low <= 1'b0; busy <= 1'b0; end
            default: shreg <= {line_in, shreg[7:1]};
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      par_err <= 1'b0;
    end else begin
      if (full_set) begin
        rx_full <= 1'b1;
        rx_data <= shreg;
      end else if (full_clr) begin
        rx_full <= 1'b0;
      end
      if (perr_set)      par_err <= 1'b1;
      else if (perr_clr) par_err <= 1'b0;
    end
  end

  assign eri_req = par_err & rx_ie;
  assign rxi_req = rx_full & rx_ie & ~rx_mask;

  // R5
  no_full_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> !$rose(rx_full));
  // R4
  data_only_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_full);
  // R6
  pull_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_low |-> busy);
  // R6
  release_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_pull_low) |-> !busy);
  // R2
  start_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line_q);
  // R3
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bitn <= 4'd11);
endmodule

// File: tb/sc_t0_rx_bench.sv
module sc_t0_rx_bench;
  localparam int CPB  = 372;
  localparam int HALF = CPB / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic card_low = 1'b0, full_clr = 1'b0, perr_clr = 1'b0, rx_ie = 1'b0, rx_mask = 1'b0;
  logic line_pull_low, rx_full, par_err, rxi_req, eri_req;
  logic [7:0] rx_data;
  wire line_in = ~(card_low | line_pull_low);

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sc_t0_rx #(.CPB(CPB)) u_sc_t0_rx (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_pull_low(line_pull_low),
    .full_clr(full_clr), .perr_clr(perr_clr), .rx_ie(rx_ie), .rx_mask(rx_mask),
    .rx_data(rx_data), .rx_full(rx_full), .par_err(par_err),
    .rxi_req(rxi_req), .eri_req(eri_req));

  // behavioural reference
  bit m_busy, m_prev = 1'b1, m_full, m_per, m_pull;
  bit [7:0] m_data, m_sh;
  int m_j;
  int pull_cycles = 0;
  bit seen_per = 1'b0, seen_full = 1'b0;

  always @(posedge clk) begin
    bit lv;
    lv = line_in;
    if (!rst_n) begin
      m_busy = 0; m_prev = 1; m_full = 0; m_per = 0; m_pull = 0; m_data = 0; m_sh = 0;
    end else begin
      bit set_f, set_p;
      set_f = 0; set_p = 0;
      if (!m_busy) begin
        if (m_prev && !lv) begin m_busy = 1; m_j = 0; end
      end else begin
        m_j++;
        if (m_j % CPB == HALF) begin
          case (m_j / CPB)
            0: if (lv) m_busy = 0;
            9: if ((^m_sh) ^ lv) set_p = 1;
               else begin set_f = 1; m_data = m_sh; m_busy = 0; end
            10: m_pull = 1;
            11: begin m_pull = 0; m_busy = 0; end
            default: m_sh[m_j / CPB - 1] = lv;
          endcase
        end
      end
      if (set_f) m_full = 1; else if (full_clr) m_full = 0;
      if (set_p) m_per = 1; else if (perr_clr) m_per = 0;
      m_prev = lv;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 rx_data", rx_data, m_data);
      chk("R4 rx_full", {7'd0, rx_full}, {7'd0, m_full});
      chk("R5 par_err", {7'd0, par_err}, {7'd0, m_per});
      chk("R6 pull", {7'd0, line_pull_low}, {7'd0, m_pull});
      chk("R9 eri", {7'd0, eri_req}, {7'd0, m_per & rx_ie});
      chk("R10 rxi", {7'd0, rxi_req}, {7'd0, m_full & rx_ie & ~rx_mask});
      if (line_pull_low) pull_cycles++;
      if (par_err) seen_per = 1;
      if (rx_full) seen_full = 1;
    end
  end

  task automatic send(input logic [7:0] d, input bit bad);
    logic [9:0] bits;
    bits = {(^d) ^ bad, d[7:0]} << 1;
    for (int k = 0; k < 10; k++) begin
      card_low = ~bits[k];
      repeat (CPB) @(negedge clk);
    end
    card_low = 1'b0;
    repeat (3 * CPB) @(negedge clk);
  endtask

  task automatic pulse_full_clr; full_clr = 1; @(negedge clk); full_clr = 0; endtask
  task automatic pulse_perr_clr; perr_clr = 1; @(negedge clk); perr_clr = 0; endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1
    chk("R1 data", rx_data, 8'h00);
    chk("R1 flags", {3'd0, rx_full, par_err, line_pull_low, rxi_req, eri_req}, 8'h00);
    rst_n = 1;
    repeat (3) @(negedge clk);
    rx_ie = 1;

    send(8'hA5, 0);  // R3 R4
    chk("R4 good data", rx_data, 8'hA5);
    chk("R10 rxi on", {7'd0, rxi_req}, 8'd1);

    pulse_full_clr();  // R8
    chk("R8 cleared", {7'd0, rx_full}, 8'd0);
    pull_cycles = 0;
    send(8'h3C, 1);  // R5 R6
    chk("R5 perr", {7'd0, par_err}, 8'd1);
    chk("R5 data kept", rx_data, 8'hA5);
    chk("R5 full kept", {7'd0, rx_full}, 8'd0);
    chk("R6 pull length", pull_cycles[7:0], 8'(CPB));
    chk("R9 eri on", {7'd0, eri_req}, 8'd1);
    pulse_perr_clr();  // R7
    chk("R7 cleared", {7'd0, par_err}, 8'd0);

    rx_mask = 1;
    pull_cycles = 0;
    send(8'h00, 0);  // R10
    chk("R4 zero byte", rx_data, 8'h00);
    chk("R10 masked", {7'd0, rxi_req}, 8'd0);
    chk("R6 no pull good", pull_cycles[7:0], 8'd0);
    rx_mask = 0;

    card_low = 1;  // R2 glitch
    repeat (HALF / 2) @(negedge clk);
    card_low = 0;
    repeat (2 * CPB) @(negedge clk);
    chk("R2 glitch data", rx_data, 8'h00);
    chk("R2 glitch flags", {6'd0, rx_full, par_err}, 8'b10);

    seen_per = 0;
    perr_clr = 1;
    send(8'hFF, 1);  // R7 set wins
    perr_clr = 0;
    chk("R7 set wins", {7'd0, seen_per}, 8'd1);
    chk("R7 end clear", {7'd0, par_err}, 8'd0);

    pulse_full_clr();
    seen_full = 0;
    full_clr = 1;
    send(8'h81, 0);  // R8 set wins
    full_clr = 0;
    chk("R8 set wins", {7'd0, seen_full}, 8'd1);
    chk("R4 data 81", rx_data, 8'h81);

    rx_ie = 0;
    send(8'h5A, 1);  // R9
    chk("R9 perr set", {7'd0, par_err}, 8'd1);
    chk("R9 eri off", {7'd0, eri_req}, 8'd0);
    chk("R10 rxi off", {7'd0, rxi_req}, 8'd0);

    send(8'h6B, 0);  // R3 after error
    chk("R3 resync", rx_data, 8'h6B);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule